// File: doc/BRIEF.md
# AUX Request Dispatcher with I2C Transaction Continuation

This block accepts display-link auxiliary-channel requests and steers each one to one of two byte-level targets. A request carries a 4-bit command, a 20-bit address, a byte count of 0 to 16 and a 16-byte data buffer. Native commands read or write a byte-wide register space, one byte per handshake, at consecutive addresses. I2C commands drive a byte-level I2C master through four operations: start with address and direction, byte transfer, stop, and a busy flag it reports. Every request finishes with a one-cycle reply pulse that carries a 2-bit reply code, the count of bytes moved, and the buffer. Read data is written back into the buffer.

Plain I2C requests always close the bus when they finish. Continuation-mode I2C requests keep the bus open and record the address and command they used. A later continuation request with the same address and command carries on the open transaction without a new start. A change of address or command closes the open transaction and starts a new one.

Top module: `auxreq_router`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is taken on a cycle with `req_valid` and `req_ready` both high. The reply is a single-cycle `rsp_valid` pulse, and `req_ready` is high again on the next cycle.
- R2: The supported command codes are 4'h8 native write, 4'h9 native read, 4'h0 I2C write, 4'h1 I2C read, 4'h4 continuation I2C write and 4'h5 continuation I2C read. Any other code replies NACK (2'b01) and causes no register access and no I2C operation.
- R3: A native request of length n makes n register accesses at addresses base, base+1, ... (modulo 2^20). Access i writes buffer byte i (bits 8i+7:8i). A read access stores its returned byte in buffer byte i.
- R4: A native request replies ACK (2'b00) when every access succeeds. At the first access that reports an error it stops and replies NACK (2'b01), and `rsp_count` equals the number of accesses that succeeded.
- R5: A native request of length 0 replies NACK and makes no register access.
- R6: A plain I2C request first issues a stop if the I2C bus reports busy. It then issues a start to address bits 6:0, with `i2c_wr` = 1 for write and 0 for read.
- R7: A plain I2C request whose start fails replies I2C NACK (2'b10) with no byte transfer and no stop. After a successful start it transfers bytes until the length is reached or a byte fails, and then always issues a stop. The reply is ACK when all bytes succeed and I2C NACK otherwise.
- R8: A continuation request on an idle bus issues a start. On a busy bus it issues a stop and then a start if its address or command differs from the recorded pair. Otherwise it issues neither, and goes straight to byte transfer (or to the reply when the length is 0).
- R9: A continuation request replies I2C NACK if its start fails. A byte failure issues a stop and replies I2C NACK. When all bytes succeed it replies ACK and issues no stop.
- R10: The recorded address/command pair is replaced only by a continuation request whose start succeeds. Plain I2C requests and failed starts leave it unchanged. After reset the pair is address 0 with command 4'h0.
- R11: In the reply, `rsp_count` is the number of bytes moved. For reads, buffer bytes 0 to `rsp_count`-1 hold the returned data. All other buffer bytes keep the request's data.
- R12: At most one operation is outstanding at a time: `reg_req` and `i2c_op_valid` are never high together. Each one holds its address, operation and data stable until its done strobe (`reg_ack` or `i2c_done`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken |
| req_cmd | input | 4 | Command code |
| req_addr | input | ADDR_W | Register address or I2C address (bits 6:0) |
| req_len | input | LEN_W | Byte count, 0 to MAX_LEN |
| req_data | input | 8*MAX_LEN | Request buffer, byte i at bits 8i+7:8i |
| rsp_valid | output | 1 | Reply pulse |
| rsp_code | output | 2 | 00 ACK, 01 NACK, 10 I2C NACK |
| rsp_count | output | LEN_W | Bytes moved |
| rsp_data | output | 8*MAX_LEN | Buffer after the request |
| reg_req | output | 1 | Register access pending |
| reg_we | output | 1 | Register access is a write |
| reg_addr | output | ADDR_W | Register address |
| reg_wdata | output | 8 | Register write byte |
| reg_ack | input | 1 | Register access done |
| reg_err | input | 1 | Register access failed (with reg_ack) |
| reg_rdata | input | 8 | Register read byte (with reg_ack) |
| i2c_op_valid | output | 1 | I2C operation pending |
| i2c_op | output | 2 | 00 start, 01 byte transfer, 10 stop |
| i2c_addr | output | 7 | I2C target address |
| i2c_wr | output | 1 | Direction, 1 write |
| i2c_wdata | output | 8 | Byte to send |
| i2c_done | input | 1 | I2C operation done |
| i2c_fail | input | 1 | Start or byte not acknowledged (with i2c_done) |
| i2c_rdata | input | 8 | Received byte (with i2c_done) |
| i2c_busy | input | 1 | I2C transaction open |

## Verification
The bench uses the default parameters, ADDR_W = 20 and MAX_LEN = 16. This allows full 16-byte bursts, and native bursts that run into the bench target's error region at low byte 0xC0 partway through. The 20-bit address lets one continuation address share its low seven bits with another (0x050 and 0x150). That case shows that a restart decision compares the whole recorded address, not only the I2C part.

// File: rtl/auxreq_pkg.sv
package auxreq_pkg;

  typedef enum logic [1:0] {
    RPL_ACK      = 2'b00,
    RPL_NACK     = 2'b01,
    RPL_I2C_NACK = 2'b10
  } reply_e;

  typedef enum logic [1:0] {
    OP_START = 2'b00,
    OP_XFER  = 2'b01,
    OP_STOP  = 2'b10
  } i2c_op_e;

  typedef enum logic [1:0] {
    CLS_BAD,
    CLS_NAT,
    CLS_I2C,
    CLS_MOT
  } cls_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NAT,
    ST_PRESTOP,
    ST_START,
    ST_XFER,
    ST_STOP,
    ST_DONE
  } state_e;

  localparam logic [3:0] CMD_I2C_WR = 4'h0;
  localparam logic [3:0] CMD_I2C_RD = 4'h1;
  localparam logic [3:0] CMD_MOT_WR = 4'h4;
  localparam logic [3:0] CMD_MOT_RD = 4'h5;
  localparam logic [3:0] CMD_NAT_WR = 4'h8;
  localparam logic [3:0] CMD_NAT_RD = 4'h9;

  function automatic cls_e classify(input logic [3:0] c);
    cls_e r;
    unique case (c)
      CMD_NAT_WR, CMD_NAT_RD: r = CLS_NAT;
      CMD_I2C_WR, CMD_I2C_RD: r = CLS_I2C;
      CMD_MOT_WR, CMD_MOT_RD: r = CLS_MOT;
      default:                r = CLS_BAD;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/auxreq_buf.sv
module auxreq_buf #(
  parameter int MAX_LEN = 16,
  localparam int IDX_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
  input  logic                 clk,
  input  logic                 load_en,
  input  logic [MAX_LEN*8-1:0] load_data,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [7:0]           wr_byte,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [7:0]           rd_byte,
  output logic [MAX_LEN*8-1:0] all_data
);

  logic [7:0] bytes_q [MAX_LEN];

  for (genvar g = 0; g < MAX_LEN; g++) begin : g_byte
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (load_en) begin
        bytes_q[g] <= load_data[g*8 +: 8];
      end else if (hit) begin
        bytes_q[g] <= wr_byte;
      end
    end
    assign all_data[g*8 +: 8] = bytes_q[g];
  end

  assign rd_byte = bytes_q[rd_idx];

endmodule

// File: rtl/auxreq_mot_track.sv
module auxreq_mot_track #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic [3:0]        upd_cmd,
  input  logic [ADDR_W-1:0] cmp_addr,
  input  logic [3:0]        cmp_cmd,
  output logic              differ
);

  logic [ADDR_W-1:0] last_addr_q, last_addr_d;
  logic [3:0]        last_cmd_q,  last_cmd_d;

  always_comb begin
    last_addr_d = last_addr_q;
    last_cmd_d  = last_cmd_q;
    if (upd_en) begin
      last_addr_d = upd_addr;
      last_cmd_d  = upd_cmd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_addr_q <= '0;
      last_cmd_q  <= 4'h0;
    end else begin
      last_addr_q <= last_addr_d;
      last_cmd_q  <= last_cmd_d;
    end
  end

  assign differ = (cmp_addr != last_addr_q) || (cmp_cmd != last_cmd_q);

  // R10: without an update the recorded pair does not move
  a_r10_record_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(last_addr_q) && $stable(last_cmd_q));

endmodule

// File: rtl/auxreq_fsm.sv
module auxreq_fsm
  import auxreq_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int MAX_LEN = 16,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [3:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              i2c_busy,
  input  logic              differ,
  input  logic [7:0]        buf_byte,
  input  logic              reg_ack,
  input  logic              reg_err,
  input  logic [7:0]        reg_rdata,
  input  logic              i2c_done,
  input  logic              i2c_fail,
  input  logic [7:0]        i2c_rdata,
  output logic              req_ready,
  output logic              load_en,
  output logic              wr_en,
  output logic [7:0]        wr_byte,
  output logic [LEN_W-1:0]  cnt,
  output logic              track_upd,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [3:0]        cur_cmd,
  output logic              reg_req,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [7:0]        reg_wdata,
  output logic              i2c_op_valid,
  output logic [1:0]        i2c_op,
  output logic [6:0]        i2c_addr,
  output logic              i2c_wr,
  output logic [7:0]        i2c_wdata,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code
);

  state_e            state_q, state_d;
  logic [3:0]        cmd_q, cmd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  reply_e            code_q, code_d;
  logic [LEN_W-1:0]  cnt_inc;
  logic              is_mot, is_read;

  assign cnt_inc = cnt_q + LEN_W'(1);
  assign is_mot  = (classify(cmd_q) == CLS_MOT);
  assign is_read = cmd_q[0];

  always_comb begin
    state_d   = state_q;
    cmd_d     = cmd_q;
    addr_d    = addr_q;
    len_d     = len_q;
    cnt_d     = cnt_q;
    code_d    = code_q;
    load_en   = 1'b0;
    wr_en     = 1'b0;
    wr_byte   = 8'h00;
    track_upd = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          load_en = 1'b1;
          cmd_d   = req_cmd;
          addr_d  = req_addr;
          len_d   = req_len;
          cnt_d   = '0;
          code_d  = RPL_ACK;
          unique case (classify(req_cmd))
            CLS_NAT: begin
              if (req_len == '0) begin
                code_d  = RPL_NACK;
                state_d = ST_DONE;
              end else begin
                state_d = ST_NAT;
              end
            end
            CLS_I2C: state_d = i2c_busy ? ST_PRESTOP : ST_START;
            CLS_MOT: begin
              if (!i2c_busy)           state_d = ST_START;
              else if (differ)         state_d = ST_PRESTOP;
              else if (req_len == '0)  state_d = ST_DONE;
              else                     state_d = ST_XFER;
            end
            default: begin
              code_d  = RPL_NACK;
              state_d = ST_DONE;
            end
          endcase
        end
      end
      ST_NAT: begin
        if (reg_ack) begin
          if (reg_err) begin
            code_d  = RPL_NACK;
            state_d = ST_DONE;
          end else begin
            wr_en   = is_read;
            wr_byte = reg_rdata;
            cnt_d   = cnt_inc;
            if (cnt_inc == len_q) state_d = ST_DONE;
          end
        end
      end
      ST_PRESTOP: begin
        if (i2c_done) state_d = ST_START;
      end
      ST_START: begin
        if (i2c_done) begin
          if (i2c_fail) begin
            code_d  = RPL_I2C_NACK;
            state_d = ST_DONE;
          end else begin
            track_upd = is_mot;
            if (len_q == '0) state_d = is_mot ? ST_DONE : ST_STOP;
            else             state_d = ST_XFER;
          end
        end
      end
      ST_XFER: begin
        if (i2c_done) begin
          if (i2c_fail) begin
            code_d  = RPL_I2C_NACK;
            state_d = ST_STOP;
          end else begin
            wr_en   = is_read;
            wr_byte = i2c_rdata;
            cnt_d   = cnt_inc;
            if (cnt_inc == len_q) state_d = is_mot ? ST_DONE : ST_STOP;
          end
        end
      end
      ST_STOP: begin
        if (i2c_done) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cmd_q   <= 4'h0;
      addr_q  <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      code_q  <= RPL_ACK;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      addr_q  <= addr_d;
      len_q   <= len_d;
      cnt_q   <= cnt_d;
      code_q  <= code_d;
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign rsp_valid    = (state_q == ST_DONE);
  assign rsp_code     = code_q;
  assign cnt          = cnt_q;
  assign cur_addr     = addr_q;
  assign cur_cmd      = cmd_q;
  assign reg_req      = (state_q == ST_NAT);
  assign reg_we       = !is_read;
  assign reg_addr     = addr_q + ADDR_W'(cnt_q);
  assign reg_wdata    = buf_byte;
  assign i2c_op_valid = (state_q == ST_PRESTOP) || (state_q == ST_START) ||
                        (state_q == ST_XFER) || (state_q == ST_STOP);
  assign i2c_op       = (state_q == ST_START) ? OP_START :
                        (state_q == ST_XFER)  ? OP_XFER  : OP_STOP;
  assign i2c_addr     = addr_q[6:0];
  assign i2c_wr       = !is_read;
  assign i2c_wdata    = buf_byte;

  // R12: never two outstanding operations
  a_r12_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_req, i2c_op_valid}));

  // R12: a register access is held until acknowledged
  a_r12_reg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_ack |=> reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata));

  // R12: an I2C operation is held until done
  a_r12_op_hold: assert property (@(posedge clk) disable iff (!rst_n)
    i2c_op_valid && !i2c_done |=> i2c_op_valid && $stable(i2c_op) && $stable(i2c_addr) && $stable(i2c_wdata));

  // R1: reply is a single pulse followed by readiness
  a_r1_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);

  // R7: failed start replies at once without a stop
  a_r7_start_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START) && i2c_done && i2c_fail |=> rsp_valid && (rsp_code == 2'b10));

  // R11: progress never runs past the requested length
  a_r11_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (cnt_q <= len_q));

endmodule

// File: rtl/auxreq_router.sv
module auxreq_router
  import auxreq_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int MAX_LEN = 16,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [3:0]           req_cmd,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [LEN_W-1:0]     req_len,
  input  logic [MAX_LEN*8-1:0] req_data,
  output logic                 rsp_valid,
  output logic [1:0]           rsp_code,
  output logic [LEN_W-1:0]     rsp_count,
  output logic [MAX_LEN*8-1:0] rsp_data,
  output logic                 reg_req,
  output logic                 reg_we,
  output logic [ADDR_W-1:0]    reg_addr,
  output logic [7:0]           reg_wdata,
  input  logic                 reg_ack,
  input  logic                 reg_err,
  input  logic [7:0]           reg_rdata,
  output logic                 i2c_op_valid,
  output logic [1:0]           i2c_op,
  output logic [6:0]           i2c_addr,
  output logic                 i2c_wr,
  output logic [7:0]           i2c_wdata,
  input  logic                 i2c_done,
  input  logic                 i2c_fail,
  input  logic [7:0]           i2c_rdata,
  input  logic                 i2c_busy
);

  localparam int IDX_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  logic              load_en, wr_en, track_upd, differ;
  logic [7:0]        wr_byte, buf_byte;
  logic [LEN_W-1:0]  cnt;
  logic [ADDR_W-1:0] cur_addr;
  logic [3:0]        cur_cmd;

  auxreq_fsm #(.ADDR_W(ADDR_W), .MAX_LEN(MAX_LEN)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len),
    .i2c_busy(i2c_busy), .differ(differ), .buf_byte(buf_byte),
    .reg_ack(reg_ack), .reg_err(reg_err), .reg_rdata(reg_rdata),
    .i2c_done(i2c_done), .i2c_fail(i2c_fail), .i2c_rdata(i2c_rdata),
    .req_ready(req_ready), .load_en(load_en), .wr_en(wr_en), .wr_byte(wr_byte),
    .cnt(cnt), .track_upd(track_upd), .cur_addr(cur_addr), .cur_cmd(cur_cmd),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .i2c_op_valid(i2c_op_valid), .i2c_op(i2c_op), .i2c_addr(i2c_addr),
    .i2c_wr(i2c_wr), .i2c_wdata(i2c_wdata),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code)
  );

  auxreq_buf #(.MAX_LEN(MAX_LEN)) u_buf (
    .clk(clk), .load_en(load_en), .load_data(req_data),
    .wr_en(wr_en), .wr_idx(cnt[IDX_W-1:0]), .wr_byte(wr_byte),
    .rd_idx(cnt[IDX_W-1:0]), .rd_byte(buf_byte), .all_data(rsp_data)
  );

  auxreq_mot_track #(.ADDR_W(ADDR_W)) u_track (
    .clk(clk), .rst_n(rst_n),
    .upd_en(track_upd), .upd_addr(cur_addr), .upd_cmd(cur_cmd),
    .cmp_addr(req_addr), .cmp_cmd(req_cmd), .differ(differ)
  );

  assign rsp_count = cnt;

  logic accept;
  assign accept = req_valid && req_ready;

  // R2: unknown command answers NACK on the next cycle
  a_r2_bad_nack: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (classify(req_cmd) == CLS_BAD) |=> rsp_valid && (rsp_code == 2'b01));

  // R5: zero-length native request answers NACK with no access
  a_r5_zero_native: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (classify(req_cmd) == CLS_NAT) && (req_len == '0)
      |=> rsp_valid && (rsp_code == 2'b01) && !reg_req);

  // R8: matching continuation on a busy bus goes straight to byte transfer
  a_r8_continue: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (classify(req_cmd) == CLS_MOT) && i2c_busy && !differ && (req_len != '0)
      |=> i2c_op_valid && (i2c_op == 2'b01));

  // R12: requested length fits the buffer
  a_r12_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (req_len <= LEN_W'(MAX_LEN)));

endmodule

// File: tb/test_auxreq_router.sv
`timescale 1ns/1ps
module test_auxreq_router;

  localparam int ADDR_W  = 20;
  localparam int MAX_LEN = 16;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic                 req_valid = 1'b0;
  logic                 req_ready;
  logic [3:0]           req_cmd = 4'h0;
  logic [ADDR_W-1:0]    req_addr = '0;
  logic [LEN_W-1:0]     req_len = '0;
  logic [MAX_LEN*8-1:0] req_data = '0;
  logic                 rsp_valid;
  logic [1:0]           rsp_code;
  logic [LEN_W-1:0]     rsp_count;
  logic [MAX_LEN*8-1:0] rsp_data;
  logic                 reg_req, reg_we;
  logic [ADDR_W-1:0]    reg_addr;
  logic [7:0]           reg_wdata;
  logic                 reg_ack = 1'b0, reg_err = 1'b0;
  logic [7:0]           reg_rdata = 8'h00;
  logic                 i2c_op_valid;
  logic [1:0]           i2c_op;
  logic [6:0]           i2c_addr;
  logic                 i2c_wr;
  logic [7:0]           i2c_wdata;
  logic                 i2c_done = 1'b0, i2c_fail = 1'b0;
  logic [7:0]           i2c_rdata = 8'h00;
  logic                 t_busy = 1'b0;

  auxreq_router #(.ADDR_W(ADDR_W), .MAX_LEN(MAX_LEN)) i_auxreq_router (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_len(req_len), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_count(rsp_count), .rsp_data(rsp_data),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_ack(reg_ack), .reg_err(reg_err), .reg_rdata(reg_rdata),
    .i2c_op_valid(i2c_op_valid), .i2c_op(i2c_op), .i2c_addr(i2c_addr), .i2c_wr(i2c_wr),
    .i2c_wdata(i2c_wdata), .i2c_done(i2c_done), .i2c_fail(i2c_fail),
    .i2c_rdata(i2c_rdata), .i2c_busy(t_busy)
  );

  int checks = 0;
  int errors = 0;

  // ---------------- target models ----------------
  logic [7:0] tmem [256];
  int n_start = 0, n_stop = 0, n_xfer = 0, n_reg = 0, overlap = 0;
  int reg_wait = 0, i2c_wait = 0;
  int t_ptr = 0;
  logic [6:0] t_cur = 7'h00;
  int rd_fail_at = 999;

  function automatic bit nat_bad(input logic [ADDR_W-1:0] a);
    return (a[19:8] != 12'h000) || (a[7:6] == 2'b11);
  endfunction

  function automatic bit present(input logic [6:0] a);
    return (a == 7'h50) || (a == 7'h3A);
  endfunction

  function automatic logic [7:0] rd_byte(input logic [6:0] a, input int p);
    return {1'b0, a} ^ 8'(p * 7);
  endfunction

  always @(posedge clk) begin
    if (reg_req && i2c_op_valid) overlap <= overlap + 1;
  end

  always @(posedge clk) begin : reg_model
    bit e;
    if (reg_ack) reg_ack <= 1'b0;
    else if (reg_req) begin
      if (reg_wait != 0) reg_wait <= reg_wait - 1;
      else begin
        e = nat_bad(reg_addr);
        reg_ack  <= 1'b1;
        reg_err  <= e;
        reg_wait <= $urandom % 3;
        n_reg    <= n_reg + 1;
        if (!e) begin
          if (reg_we) tmem[reg_addr[7:0]] <= reg_wdata;
          else        reg_rdata <= tmem[reg_addr[7:0]];
        end
      end
    end
  end

  always @(posedge clk) begin : i2c_model
    bit f;
    if (i2c_done) i2c_done <= 1'b0;
    else if (i2c_op_valid) begin
      if (i2c_wait != 0) i2c_wait <= i2c_wait - 1;
      else begin
        i2c_done <= 1'b1;
        i2c_wait <= $urandom % 3;
        case (i2c_op)
          2'b00: begin
            n_start <= n_start + 1;
            if (present(i2c_addr)) begin
              t_busy <= 1'b1; t_ptr <= 0; t_cur <= i2c_addr; i2c_fail <= 1'b0;
            end else i2c_fail <= 1'b1;
          end
          2'b01: begin
            n_xfer <= n_xfer + 1;
            f = i2c_wr ? (i2c_wdata == 8'hEE) : (t_ptr == rd_fail_at);
            i2c_fail <= f;
            if (!f) begin
              if (!i2c_wr) i2c_rdata <= rd_byte(t_cur, t_ptr);
              t_ptr <= t_ptr + 1;
            end
          end
          default: begin
            n_stop <= n_stop + 1; t_busy <= 1'b0; i2c_fail <= 1'b0;
          end
        endcase
      end
    end
  end

  // ---------------- reference model ----------------
  logic [7:0]        rmem [256];
  bit                r_busy = 1'b0;
  logic [ADDR_W-1:0] r_last_a = '0;
  logic [3:0]        r_last_c = 4'h0;
  int                r_ptr = 0;
  logic [6:0]        r_cur = 7'h00;

  task automatic ref_run(input logic [3:0] c, input logic [ADDR_W-1:0] a, input int n,
                         input logic [MAX_LEN*8-1:0] d, output logic [1:0] code,
                         output int cnt, output logic [MAX_LEN*8-1:0] od,
                         output int st, output int sp, output int xf, output int ra);
    bit rd;
    logic [ADDR_W-1:0] ad;
    logic [7:0] b;
    rd = c[0]; od = d; cnt = 0; st = 0; sp = 0; xf = 0; ra = 0;
    if (c == 4'h8 || c == 4'h9) begin
      code = (n == 0) ? 2'b01 : 2'b00;
      for (int i = 0; i < n; i++) begin
        ad = a + ADDR_W'(i); ra++;
        if (nat_bad(ad)) begin code = 2'b01; break; end
        if (rd) od[i*8 +: 8] = rmem[ad[7:0]];
        else    rmem[ad[7:0]] = d[i*8 +: 8];
        cnt++;
      end
    end else if (c == 4'h0 || c == 4'h1) begin
      if (r_busy) begin sp++; r_busy = 0; end
      st++;
      if (!present(a[6:0])) begin code = 2'b10; return; end
      r_busy = 1; r_ptr = 0; r_cur = a[6:0]; code = 2'b00;
      for (int i = 0; i < n; i++) begin
        xf++; b = d[i*8 +: 8];
        if (rd ? (r_ptr == rd_fail_at) : (b == 8'hEE)) begin code = 2'b10; break; end
        if (rd) od[i*8 +: 8] = rd_byte(r_cur, r_ptr);
        r_ptr++; cnt++;
      end
      sp++; r_busy = 0;
    end else if (c == 4'h4 || c == 4'h5) begin
      code = 2'b10;
      if (!r_busy || a != r_last_a || c != r_last_c) begin
        if (r_busy) begin sp++; r_busy = 0; end
        st++;
        if (!present(a[6:0])) return;
        r_busy = 1; r_ptr = 0; r_cur = a[6:0];
      end
      r_last_a = a; r_last_c = c;
      for (int i = 0; i < n; i++) begin
        xf++; b = d[i*8 +: 8];
        if (rd ? (r_ptr == rd_fail_at) : (b == 8'hEE)) begin sp++; r_busy = 0; break; end
        if (rd) od[i*8 +: 8] = rd_byte(r_cur, r_ptr);
        r_ptr++; cnt++;
      end
      if (cnt == n) code = 2'b00;
    end else begin
      code = 2'b01;
    end
  endtask

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_vec(input string tag, input logic [MAX_LEN*8-1:0] act,
                         input logic [MAX_LEN*8-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s buffer actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic [3:0] c, input logic [ADDR_W-1:0] a, input int n,
                         input logic [MAX_LEN*8-1:0] d);
    logic [1:0] ec; int ecnt; logic [MAX_LEN*8-1:0] ed;
    int est, esp, exf, era, b_st, b_sp, b_xf, b_ra;
    string tag;
    case (c)
      4'h8, 4'h9: tag = (n == 0) ? "R5" : "R3/R4";
      4'h0, 4'h1: tag = "R6/R7";
      4'h4, 4'h5: tag = "R8/R9/R10";
      default:    tag = "R2";
    endcase
    ref_run(c, a, n, d, ec, ecnt, ed, est, esp, exf, era);
    @(negedge clk);
    b_st = n_start; b_sp = n_stop; b_xf = n_xfer; b_ra = n_reg;
    chk(req_ready == 1'b1, "R1", "ready before request", req_ready, 1);
    req_valid = 1'b1; req_cmd = c; req_addr = a; req_len = LEN_W'(n); req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1", "ready after accept", req_ready, 0);
    while (!rsp_valid) @(negedge clk);
    chk(rsp_code == ec, tag, "reply code", rsp_code, ec);
    chk(int'(rsp_count) == ecnt, "R11", "byte count", rsp_count, ecnt);
    chk_vec("R11", rsp_data, ed);
    chk(n_start - b_st == est, tag, "starts", n_start - b_st, est);
    chk(n_stop - b_sp == esp, tag, "stops", n_stop - b_sp, esp);
    chk(n_xfer - b_xf == exf, tag, "byte transfers", n_xfer - b_xf, exf);
    chk(n_reg - b_ra == era, tag, "register accesses", n_reg - b_ra, era);
    @(negedge clk);
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R1", "pulse end", {rsp_valid, req_ready}, 2'b01);
  endtask

  function automatic logic [MAX_LEN*8-1:0] rand_data();
    logic [MAX_LEN*8-1:0] v;
    for (int i = 0; i < MAX_LEN; i++) begin
      v[i*8 +: 8] = 8'($urandom);
      if (v[i*8 +: 8] == 8'hEE) v[i*8 +: 8] = 8'hED;
    end
    return v;
  endfunction

  initial begin : watchdog
    #(1_900_000ns);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [MAX_LEN*8-1:0] d;
    logic [3:0] cmds [9];
    logic [ADDR_W-1:0] i2c_addrs [4];
    void'($urandom(32'd20117));
    cmds = '{4'h8, 4'h9, 4'h0, 4'h1, 4'h4, 4'h5, 4'h4, 4'h5, 4'h2};
    i2c_addrs = '{20'h00050, 20'h0003A, 20'h00011, 20'h00150};
    for (int i = 0; i < 256; i++) begin
      tmem[i] = 8'(i) ^ 8'h5A;
      rmem[i] = 8'(i) ^ 8'h5A;
    end
    repeat (3) @(negedge clk);
    // reset state (R1, R12)
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1", "reset ready/valid", {req_ready, rsp_valid}, 2'b10);
    chk(reg_req == 1'b0 && i2c_op_valid == 1'b0, "R12", "reset ports idle", {reg_req, i2c_op_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 unknown codes
    run_req(4'h2, 20'h00010, 3, rand_data());
    run_req(4'hA, 20'h00010, 3, rand_data());
    // R5 zero-length native
    run_req(4'h8, 20'h00010, 0, rand_data());
    // R3/R4 native write then read back, and a burst into the error region
    run_req(4'h8, 20'h00010, 4, rand_data());
    run_req(4'h9, 20'h00010, 4, rand_data());
    run_req(4'h9, 20'h000BE, 4, rand_data());
    run_req(4'h8, 20'h000F0, 16, rand_data());
    // R8/R10 continuation sequences
    run_req(4'h4, 20'h00050, 2, rand_data());
    run_req(4'h4, 20'h00050, 3, rand_data());
    run_req(4'h5, 20'h00050, 2, rand_data());
    run_req(4'h5, 20'h00150, 1, rand_data());
    run_req(4'h5, 20'h00150, 0, rand_data());
    // R6 plain request on a busy bus
    run_req(4'h0, 20'h0003A, 2, rand_data());
    // R7 failed start, R9 failed continuation start
    run_req(4'h1, 20'h00011, 3, rand_data());
    run_req(4'h4, 20'h00011, 3, rand_data());
    // R9 byte failure on a continuation write
    d = rand_data(); d[15:8] = 8'hEE;
    run_req(4'h4, 20'h00050, 4, d);
    // R7 read byte failure on a plain read
    rd_fail_at = 1;
    run_req(4'h1, 20'h00050, 4, rand_data());
    rd_fail_at = 999;
    // R7 zero-length plain request: start and stop only
    run_req(4'h0, 20'h0003A, 0, rand_data());

    // constrained random
    for (int k = 0; k < 300; k++) begin
      logic [3:0] c; logic [ADDR_W-1:0] a; int n;
      c = cmds[$urandom % 9];
      n = $urandom % (MAX_LEN + 1);
      d = rand_data();
      if (c[3]) begin
        a = ADDR_W'($urandom % 256);
        if ($urandom % 5 == 0) a[12] = 1'b1;
      end else begin
        a = i2c_addrs[$urandom % 4];
      end
      if ($urandom % 6 == 0 && n > 0) d[($urandom % n)*8 +: 8] = 8'hEE;
      rd_fail_at = ($urandom % 3 == 0) ? int'($urandom % 20) : 999;
      run_req(c, a, n, d);
    end

    chk(overlap == 0, "R12", "overlapping operations", overlap, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule